// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts activity for a processor core. It holds three 32-bit counters: one that counts clock cycles and two that count events. Each event counter picks one of 256 single-cycle event inputs through an 8-bit selector. One control word governs all three counters. It holds a global run bit, a slow rate for the cycle counter, reset pulses, interrupt enables and sticky wrap flags. A single interrupt line is raised when a flagged counter also has its enable set.

Software reaches the unit through a plain register port. A write takes effect at the next clock edge, and a read returns data combinationally. There is no way to start or stop a counter on its own. To stop one event counter, software points its selector at event code 0x20. That input is treated as permanently idle. While the counter is stopped, software can load it with any value, including zero. Wrap flags are cleared by writing 1 to them. This lets software clear the flags by writing back the control word it has just read.

Top module: `perf_monitor`

## Requirements
- R1: After reset, the control word reads 0x00000000, all three counters read 0 and `irqOut` is low.
- R2: Control bit 0 runs all counters at once. While it is 0, no counter changes except through a direct write or a reset bit. While it is 1 and bit 3 is 0, the cycle counter adds 1 on every clock.
- R3: While bits 0 and 3 are both 1, the cycle counter adds 1 once for every 64 enabled clocks. The 64-clock count restarts from zero when the cycle counter is written or reset.
- R4: The selector for event counter 0 is control bits 27:20, and the selector for event counter 1 is bits 19:12. An event counter adds 1 on every enabled clock where `evtIn[selector]` is 1.
- R5: A selector value of 0x20 never counts, whatever the level of `evtIn[32]`.
- R6: Address 0 is the control word, address 1 the cycle counter, address 2 event counter 0 and address 3 event counter 1. A write to a counter address loads the full 32-bit value and takes priority over an increment in the same cycle.
- R7: Writing 1 to control bit 1 clears both event counters. Writing 1 to bit 2 clears the cycle counter. Both bits act as one-cycle pulses and always read back as 0.
- R8: Control bits 8, 9 and 10 are the wrap flags for event counter 0, event counter 1 and the cycle counter. A flag is set on the clock where its counter increments from 0xFFFFFFFF to 0.
- R9: Writing 1 to a wrap flag clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R10: Control bits 4, 5 and 6 enable the interrupt for event counter 0, event counter 1 and the cycle counter. `irqOut` is high exactly when some flag and its matching enable are both 1.
- R11: Control bits 7, 11 and 31:28 always read as 0. The other writable fields read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtIn | input | 256 | Event pulses, one bit per event code |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| irqOut | output | 1 | Combined overflow interrupt |

## Verification
Several properties are checked on every cycle:
- No counter moves while the unit is stopped and no write arrives.
- A counter selecting the idle code holds its value.
- The undivided cycle counter steps by exactly one.
- The divided cycle counter steps by at most one.
- Every rising wrap flag follows a 0xFFFFFFFF-to-0 step of its own counter.
- The interrupt only falls after a control write.

Some behaviours can only be shown by the bench scenarios:
- Selector decoding across all 256 codes.
- The exact 64-clock pacing of the divided rate.
- Readback masking of the control word.
- A wrap winning over a simultaneous clear.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int REG_W    = 32;
  localparam int SEL_W    = 8;
  localparam int NUM_EVT  = 1 << SEL_W;
  localparam int ADDR_W   = 2;
  localparam int NUM_CNT  = 3;
  localparam int CYC_DIV  = 64;
  localparam logic [SEL_W-1:0] IDLE_CODE = 8'h20;

  // control word field positions
  localparam int EN_BIT   = 0;
  localparam int RSTE_BIT = 1;
  localparam int RSTC_BIT = 2;
  localparam int DIV_BIT  = 3;
  localparam int IEN_LO   = 4;
  localparam int FLG_LO   = 8;
  localparam int SEL1_LO  = 12;
  localparam int SEL0_LO  = 20;

  // counter index order inside flag and enable groups
  localparam int IDX_EV0  = 0;
  localparam int IDX_EV1  = 1;
  localparam int IDX_CYC  = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CYC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EV0  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_EV1  = 2'd3;

  typedef struct packed {
    logic             enable;
    logic             divMode;
    logic [SEL_W-1:0] sel0;
    logic [SEL_W-1:0] sel1;
  } cfg_t;

  typedef struct packed {
    logic             rstEvt;
    logic             rstCyc;
    logic             wrCyc;
    logic             wrEv0;
    logic             wrEv1;
    logic [REG_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/perf_mon_ctrl.sv
module perf_mon_ctrl
  import perf_mon_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  input  logic [NUM_CNT-1:0]  wrapHit,
  output cfg_t                cfg,
  output strobe_t             strb,
  output logic [REG_W-1:0]    ctrlRead,
  output logic                irqOut
);
  cfg_t               cfgQ;
  logic [NUM_CNT-1:0] ienQ;
  logic [NUM_CNT-1:0] flagQ;
  logic [NUM_CNT-1:0] clrMask;
  logic               ctrlWr;

  assign ctrlWr  = regWrEn && (regAddr == ADDR_CTRL);
  assign clrMask = ctrlWr ? regWrData[FLG_LO +: NUM_CNT] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      ienQ  <= '0;
      flagQ <= '0;
    end else begin
      if (ctrlWr) begin
        cfgQ.enable  <= regWrData[EN_BIT];
        cfgQ.divMode <= regWrData[DIV_BIT];
        cfgQ.sel0    <= regWrData[SEL0_LO +: SEL_W];
        cfgQ.sel1    <= regWrData[SEL1_LO +: SEL_W];
        ienQ         <= regWrData[IEN_LO +: NUM_CNT];
      end
      // a wrap in this cycle wins over a clear
      flagQ <= (flagQ & ~clrMask) | wrapHit;
    end
  end

  always_comb begin
    strb        = '0;
    strb.rstEvt = ctrlWr && regWrData[RSTE_BIT];
    strb.rstCyc = ctrlWr && regWrData[RSTC_BIT];
    strb.wrCyc  = regWrEn && (regAddr == ADDR_CYC);
    strb.wrEv0  = regWrEn && (regAddr == ADDR_EV0);
    strb.wrEv1  = regWrEn && (regAddr == ADDR_EV1);
    strb.data   = regWrData;
  end

  always_comb begin
    ctrlRead                       = '0;
    ctrlRead[EN_BIT]               = cfgQ.enable;
    ctrlRead[DIV_BIT]              = cfgQ.divMode;
    ctrlRead[IEN_LO +: NUM_CNT]    = ienQ;
    ctrlRead[FLG_LO +: NUM_CNT]    = flagQ;
    ctrlRead[SEL1_LO +: SEL_W]     = cfgQ.sel1;
    ctrlRead[SEL0_LO +: SEL_W]     = cfgQ.sel0;
  end

  assign cfg    = cfgQ;
  assign irqOut = |(flagQ & ienQ);
endmodule

// File: rtl/perf_mon_datapath.sv
module perf_mon_datapath
  import perf_mon_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EVT-1:0]  evtIn,
  input  cfg_t                cfg,
  input  strobe_t             strb,
  output logic [REG_W-1:0]    cntCyc,
  output logic [REG_W-1:0]    cntEv0,
  output logic [REG_W-1:0]    cntEv1,
  output logic [NUM_CNT-1:0]  wrapHit
);
  localparam int PRE_W = $clog2(CYC_DIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_DIV - 1);
  localparam logic [REG_W-1:0] ONE = REG_W'(1);

  logic [REG_W-1:0] evCnt [2];

  for (genvar g = 0; g < 2; g++) begin : g_evt
    logic [SEL_W-1:0] sel;
    logic             wr;
    logic             hit;

    assign sel = (g == 0) ? cfg.sel0 : cfg.sel1;
    assign wr  = (g == 0) ? strb.wrEv0 : strb.wrEv1;
    assign hit = cfg.enable && evtIn[sel] && (sel != IDLE_CODE);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            evCnt[g] <= '0;
      else if (strb.rstEvt) evCnt[g] <= '0;
      else if (wr)          evCnt[g] <= strb.data;
      else if (hit)         evCnt[g] <= evCnt[g] + ONE;
    end

    assign wrapHit[g] = hit && !strb.rstEvt && !wr && (evCnt[g] == '1);
  end

  logic [PRE_W-1:0] preCnt;
  logic             cycTick;
  logic             cycLoad;

  assign cycLoad = strb.rstCyc || strb.wrCyc;
  assign cycTick = cfg.enable && (!cfg.divMode || (preCnt == PRE_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         preCnt <= '0;
    else if (cycLoad)                  preCnt <= '0;
    else if (cfg.enable && cfg.divMode) preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntCyc <= '0;
    else if (strb.rstCyc) cntCyc <= '0;
    else if (strb.wrCyc)  cntCyc <= strb.data;
    else if (cycTick)     cntCyc <= cntCyc + ONE;
  end

  assign wrapHit[IDX_CYC] = cycTick && !cycLoad && (cntCyc == '1);
  assign cntEv0 = evCnt[0];
  assign cntEv1 = evCnt[1];
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
  import perf_mon_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic               irqOut
);
  cfg_t               cfg;
  strobe_t            strb;
  logic [REG_W-1:0]   ctrlRead;
  logic [REG_W-1:0]   cntCyc;
  logic [REG_W-1:0]   cntEv0;
  logic [REG_W-1:0]   cntEv1;
  logic [NUM_CNT-1:0] wrapHit;

  perf_mon_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .wrapHit(wrapHit), .cfg(cfg), .strb(strb),
    .ctrlRead(ctrlRead), .irqOut(irqOut)
  );

  perf_mon_datapath i_dp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .cfg(cfg), .strb(strb),
    .cntCyc(cntCyc), .cntEv0(cntEv0), .cntEv1(cntEv1), .wrapHit(wrapHit)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = ctrlRead;
      ADDR_CYC:  regRdData = cntCyc;
      ADDR_EV0:  regRdData = cntEv0;
      default:   regRdData = cntEv1;
    endcase
  end
endmodule

// File: rtl/perf_monitor_chk.sv
module perf_monitor_chk
  import perf_mon_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               irqOut,
  input cfg_t               cfg,
  input logic [REG_W-1:0]   cntCyc,
  input logic [REG_W-1:0]   cntEv0,
  input logic [REG_W-1:0]   cntEv1,
  input logic [NUM_CNT-1:0] flagBits
);
  localparam logic [REG_W-1:0] ONE = REG_W'(1);

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.enable && !regWrEn) |=> ($stable(cntCyc) && $stable(cntEv0) && $stable(cntEv1))); // R2

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && !cfg.divMode && !(regWrEn && (regAddr == ADDR_CTRL || regAddr == ADDR_CYC)))
    |=> (cntCyc == $past(cntCyc) + ONE)); // R2

  AST_DIV_SLOW: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && cfg.divMode && !(regWrEn && (regAddr == ADDR_CTRL || regAddr == ADDR_CYC)))
    |=> (cntCyc == $past(cntCyc) || cntCyc == $past(cntCyc) + ONE)); // R3

  AST_IDLE_EV0: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.sel0 == IDLE_CODE && !(regWrEn && (regAddr == ADDR_CTRL || regAddr == ADDR_EV0)))
    |=> $stable(cntEv0)); // R5

  AST_IDLE_EV1: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.sel1 == IDLE_CODE && !(regWrEn && (regAddr == ADDR_CTRL || regAddr == ADDR_EV1)))
    |=> $stable(cntEv1)); // R5

  AST_WRAP_EV0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagBits[IDX_EV0]) |-> (cntEv0 == '0 && $past(cntEv0) == '1)); // R8

  AST_WRAP_EV1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagBits[IDX_EV1]) |-> (cntEv1 == '0 && $past(cntEv1) == '1)); // R8

  AST_WRAP_CYC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagBits[IDX_CYC]) |-> (cntCyc == '0 && $past(cntCyc) == '1)); // R8

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(regWrEn && regAddr == ADDR_CTRL)); // R10
endmodule

bind perf_monitor perf_monitor_chk i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .irqOut(irqOut), .cfg(cfg), .cntCyc(cntCyc), .cntEv0(cntEv0),
  .cntEv1(cntEv1), .flagBits(ctrlRead[perf_mon_pkg::FLG_LO +: perf_mon_pkg::NUM_CNT])
);

// File: tb/test_perf_monitor.sv
`timescale 1ns/1ps
module test_perf_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [255:0] evtIn = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  perf_monitor i_perf_monitor (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] cfgW;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(0, v); chk("R1 ctrl", v, 32'h0);
    rd(1, v); chk("R1 cyc", v, 32'h0);
    rd(2, v); chk("R1 ev0", v, 32'h0);
    rd(3, v); chk("R1 ev1", v, 32'h0);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);

    // R2 stopped: nothing moves
    evtIn = '1;
    tick(10);
    rd(1, v); chk("R2 stopped cyc", v, 32'h0);
    rd(2, v); chk("R2 stopped ev0", v, 32'h0);
    evtIn = '0;

    // R4 R5 R2 sweep over every selector code
    for (int c = 0; c < 256; c++) begin
      int k;
      int e0;
      int e1;
      k = (c % 5) + 1;
      wr(0, 32'h0);
      wr(1, 32'h0);
      wr(2, 32'h0);
      wr(3, 32'h0);
      wr(0, 32'h1 | (32'(c) << 20) | (32'(255 - c) << 12));
      evtIn = '0; evtIn[c] = 1'b1;
      tick(k);
      evtIn = '1;
      tick(2);
      evtIn = '0;
      e0 = (c == 32) ? 0 : k + 2;
      e1 = ((255 - c) == 32) ? 0 : 2;
      rd(2, v); chk($sformatf("R4 R5 ev0 code %0d", c), v, 32'(e0));
      rd(3, v); chk($sformatf("R4 R5 ev1 code %0d", 255 - c), v, 32'(e1));
      rd(1, v); chk("R2 cycle per clock", v, 32'(k + 2));
    end

    // R3 divided rate
    wr(0, 32'h0);
    wr(1, 32'h0);
    wr(0, 32'h9);
    tick(200);
    rd(1, v); chk("R3 after 200", v, 32'd3);
    tick(55);
    rd(1, v); chk("R3 after 255", v, 32'd3);
    tick(1);
    rd(1, v); chk("R3 after 256", v, 32'd4);
    wr(1, 32'd10);
    tick(63);
    rd(1, v); chk("R3 restart 63", v, 32'd10);
    tick(1);
    rd(1, v); chk("R3 restart 64", v, 32'd11);

    // R6 direct write beats increment
    wr(0, 32'h1);
    wr(1, 32'd500);
    rd(1, v); chk("R6 write priority", v, 32'd500);
    wr(0, 32'h0);
    wr(3, 32'hDEADBEEF);
    rd(3, v); chk("R6 load ev1", v, 32'hDEADBEEF);

    // R7 reset pulses
    wr(1, 32'd123); wr(2, 32'd456); wr(3, 32'd789);
    wr(0, 32'h2);
    rd(2, v); chk("R7 ev0 cleared", v, 32'h0);
    rd(3, v); chk("R7 ev1 cleared", v, 32'h0);
    rd(1, v); chk("R7 cyc kept", v, 32'd123);
    rd(0, v); chk("R7 reads zero", v, 32'h0);
    wr(2, 32'd55);
    wr(0, 32'h4);
    rd(1, v); chk("R7 cyc cleared", v, 32'h0);
    rd(2, v); chk("R7 ev0 kept", v, 32'd55);

    // R8 R10 event counter 0 wrap
    cfgW = 32'h1 | 32'h10 | (32'h3 << 20) | (32'h20 << 12);
    wr(2, 32'hFFFFFFFE);
    wr(0, cfgW);
    evtIn[3] = 1'b1;
    tick(1);
    rd(2, v); chk("R8 ev0 at max", v, 32'hFFFFFFFF);
    rd(0, v); chk("R8 no flag yet", v, cfgW);
    tick(1);
    evtIn = '0;
    rd(2, v); chk("R8 ev0 wrapped", v, 32'h0);
    rd(0, v); chk("R8 flag set", v, cfgW | 32'h100);
    chk("R10 irq high", {31'b0, irqOut}, 32'h1);
    wr(0, cfgW);
    rd(0, v); chk("R9 write 0 keeps flag", v, cfgW | 32'h100);
    cfgW = 32'h1 | (32'h3 << 20) | (32'h20 << 12);
    wr(0, cfgW);
    chk("R10 irq masked", {31'b0, irqOut}, 32'h0);
    rd(0, v); chk("R10 flag kept", v, cfgW | 32'h100);

    // R9 set wins over clear
    wr(2, 32'hFFFFFFFF);
    evtIn[3] = 1'b1;
    wr(0, cfgW | 32'h100);
    evtIn = '0;
    rd(2, v); chk("R9 wrap with clear", v, 32'h0);
    rd(0, v); chk("R9 set wins", v, cfgW | 32'h100);
    wr(0, cfgW | 32'h100);
    rd(0, v); chk("R9 w1c", v, cfgW);

    // R8 R10 cycle counter wrap
    wr(0, 32'h0);
    wr(1, 32'hFFFFFFFD);
    wr(0, 32'h41);
    tick(2);
    chk("R10 cyc irq low", {31'b0, irqOut}, 32'h0);
    tick(1);
    rd(0, v); chk("R8 cyc flag", v, 32'h441);
    chk("R10 cyc irq", {31'b0, irqOut}, 32'h1);
    wr(0, 32'h400);
    rd(0, v); chk("R9 cyc w1c", v, 32'h0);
    chk("R10 irq cleared", {31'b0, irqOut}, 32'h0);

    // R8 R10 event counter 1 wrap
    wr(3, 32'hFFFFFFFF);
    wr(0, 32'h21 | (32'h7 << 12) | (32'h20 << 20));
    evtIn[7] = 1'b1;
    tick(1);
    evtIn = '0;
    rd(0, v); chk("R8 ev1 flag", v, 32'h221 | (32'h7 << 12) | (32'h20 << 20));
    chk("R10 ev1 irq", {31'b0, irqOut}, 32'h1);
    wr(0, 32'h200);
    chk("R10 ev1 irq cleared", {31'b0, irqOut}, 32'h0);

    // R11 unused bits read zero
    wr(0, 32'hFFFFFFFF);
    rd(0, v); chk("R11 readback", v, 32'h0FFFF079);
    wr(0, 32'h0);
    rd(0, v); chk("R11 cleared", v, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule